// File: doc/BRIEF.md
# DRAM Word Write Sequencer

This block turns a single 32-bit word write request into the pin activity of a DRAM on a 16-bit data bus. The data lines of that bus are the upper lines D31..D16 of the external bus. Each word becomes two half-word write cycles. The first cycle writes the half-word at the lower address, using the upper 16 data bits of the request. The second writes the next half-word, using the lower 16 data bits. Each half-word cycle lasts five clock states, Q1 to Q5. In each cycle the row address goes out on the shared address pins, then the column address.

Two strobe wirings are supported. In single-CAS mode, one CAS line is shared and each byte lane has its own write enable. In dual-CAS mode, each byte lane has its own CAS line and one write enable covers both lanes. A request is accepted only while the block is idle. Its address, data, byte enables and mode are held for the whole word.

Top module: `dram_wr_seq`

## Requirements
- R1: After a synchronous active-low reset, the outputs are inactive. `busy` and `done` are 0. `ras_n`, `cs_n` and `rd_n` are 1. Both bits of `cas_n` and both bits of `we_n` are 1. `dq_oe` is 0.
- R2: A request is accepted at a clock edge where `req_valid` is 1 and `busy` is 0. From the next cycle, `busy` stays 1 for exactly ten cycles: two half-word cycles of five states Q1..Q5.
- R3: Write data is driven throughout Q1..Q5 of each half-word cycle, with `dq_oe` at 1 and `dq_o` holding that half's data. `dq_oe` is 0 in the cycle after the second Q5.
- R4: RAS (`ras_n`) is low in Q2..Q5 and high in Q1. Every CAS and WE line is high in Q1 and Q2. Strobes may be low only in Q3..Q5.
- R5: The half-word address is {`req_addr`, h}, where h is 0 for the first half and 1 for the second. `dram_addr` carries the row (half-word address shifted right by COL_W) in Q1..Q2. It carries the column (the low COL_W bits) in Q3..Q5. The first half uses `req_data[31:16]` and `req_be[3:2]`. The second half uses `req_data[15:0]` and `req_be[1:0]`.
- R6: `cs_n` is 0 in every cycle in which `busy` is 1. `rd_n` is always 1.
- R7: With `mode_sel`=0 (single CAS, two WEs), `cas_n[0]` is the shared CAS and is low in Q3..Q5, while `cas_n[1]` stays high. `we_n[0]` qualifies `dq_o[15:8]` and is low in Q3..Q5 only if the upper enable bit of the half is set. `we_n[1]` qualifies `dq_o[7:0]` and follows the lower enable bit in the same way.
- R8: With `mode_sel`=1 (two CAS lines, one WE), `cas_n[0]` serves `dq_o[15:8]` and `cas_n[1]` serves `dq_o[7:0]`. Each is low in Q3..Q5 only if its lane's enable bit is set. `we_n[0]` is the shared WE and is low in Q3..Q5, while `we_n[1]` stays high.
- R9: `mode_sel` is sampled at acceptance. Changing it while `busy` has no effect on the current word.
- R10: Requests presented while `busy` is 1 are ignored. They change neither the current word nor the state after it.
- R11: `done` is 1 for exactly one cycle, the cycle after the second Q5, in which `busy` is already 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | 0: single CAS with two WEs; 1: two CAS lines with one WE |
| req_valid | input | 1 | Write request, taken when idle |
| req_addr | input | WADDR_W | Word address of the write |
| req_data | input | 32 | Word data; bits 31:16 are written first |
| req_be | input | 4 | Byte enables; [3:2] first half, [1:0] second half |
| busy | output | 1 | High while a word write is in progress |
| done | output | 1 | One-cycle completion pulse |
| dram_addr | output | MUX_W | Multiplexed row/column address |
| dq_o | output | 16 | Data for external lines D31..D16 |
| dq_oe | output | 1 | Data output enable; 0 means high impedance |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Column strobes, active low |
| we_n | output | 2 | Write enables, active low |
| cs_n | output | 1 | Chip-select for the DRAM area, active low |
| rd_n | output | 1 | Read strobe, held inactive |

## Verification
The assertions check on every cycle that no CAS falls without RAS low and that RAS stays low for at least two cycles once it falls. They also check that a WE never goes low outside the data-drive window, that chip-select and data drive stay inside `busy`, that `done` never lasts two cycles, and that the captured request does not change while busy. Only the bench scenarios can show the exact state-by-state timing and the row-then-column address values. The same holds for the order of the two halves, the per-lane strobe mapping of each mode under partial byte enables, and the sampling of the mode at acceptance. They also show that requests made while busy leave no trace.

// File: rtl/dram_wr_pkg.sv
// Shared types for the DRAM word write sequencer.
// Assumes: one state per clock, no wait insertion.
package dram_wr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_Q1   = 3'd1,
        ST_Q2   = 3'd2,
        ST_Q3   = 3'd3,
        ST_Q4   = 3'd4,
        ST_Q5   = 3'd5
    } seq_state_t;
endpackage

// File: rtl/dram_wr_fsm.sv
// State sequencer: accepts a word request when idle, captures it, then walks
// Q1..Q5 twice (half 0 then half 1) and pulses done at the end.
// Assumes: requests while busy are dropped, not queued.
module dram_wr_fsm
    import dram_wr_pkg::*;
#(
    parameter int WADDR_W = 22,
    parameter int WORD_W  = 32,
    parameter int BE_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [WADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0]  req_data,
    input  logic [BE_W-1:0]    req_be,
    input  logic               mode_sel,
    output seq_state_t         state,
    output logic               half,
    output logic [WADDR_W-1:0] addr_q,
    output logic [WORD_W-1:0]  data_q,
    output logic [BE_W-1:0]    be_q,
    output logic               mode_q,
    output logic               busy,
    output logic               done
);

    // Busy whenever a state other than idle is active.
    assign busy = (state != ST_IDLE);

    // State walk, request capture and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            half   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            be_q   <= '0;
            mode_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        data_q <= req_data;
                        be_q   <= req_be;
                        mode_q <= mode_sel;
                        half   <= 1'b0;
                        state  <= ST_Q1;
                    end
                end
                ST_Q1: state <= ST_Q2;
                ST_Q2: state <= ST_Q3;
                ST_Q3: state <= ST_Q4;
                ST_Q4: state <= ST_Q5;
                ST_Q5: begin
                    if (!half) begin
                        half  <= 1'b1;
                        state <= ST_Q1;
                    end else begin
                        half  <= 1'b0;
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_capture_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(addr_q) && $stable(data_q) && $stable(be_q) && $stable(mode_q)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/dram_wr_addr.sv
// Address multiplexer: forms the half-word address from the captured word
// address and the half bit, then puts the row out in Q1..Q2 and the column
// out in Q3..Q5.
// Assumes: COL_W is smaller than the half-word address width.
module dram_wr_addr
    import dram_wr_pkg::*;
#(
    parameter int WADDR_W = 22,
    parameter int COL_W   = 8,
    localparam int HW_W   = WADDR_W + 1,
    localparam int ROW_W  = HW_W - COL_W,
    localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic [WADDR_W-1:0] addr_q,
    input  logic               half,
    input  seq_state_t         state,
    output logic [MUX_W-1:0]   mux_addr
);

    logic [HW_W-1:0]  hw_addr;
    logic [ROW_W-1:0] row_part;
    logic [COL_W-1:0] col_part;

    // Split the half-word address into row and column fields.
    always_comb begin
        hw_addr  = {addr_q, half};
        row_part = hw_addr[HW_W-1:COL_W];
        col_part = hw_addr[COL_W-1:0];
    end

    // Select row or column by state; zero when idle.
    always_comb begin
        unique case (state)
            ST_Q1, ST_Q2:        mux_addr = MUX_W'(row_part);
            ST_Q3, ST_Q4, ST_Q5: mux_addr = MUX_W'(col_part);
            default:             mux_addr = '0;
        endcase
    end

endmodule

// File: rtl/dram_wr_strobe.sv
// Strobe decoder: derives RAS, per-lane CAS/WE, chip-select, read strobe and
// data enable from the state, the half and the captured byte enables, for
// either strobe scheme. Lane 0 is the high byte of the half-word.
// Assumes: all strobes active low, mode held for the whole word.
module dram_wr_strobe
    import dram_wr_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_state_t         state,
    input  logic               half,
    input  logic [2*LANES-1:0] be_q,
    input  logic               mode_q,
    output logic               ras_n,
    output logic [LANES-1:0]   cas_n,
    output logic [LANES-1:0]   we_n,
    output logic               cs_n,
    output logic               rd_n,
    output logic               dq_oe
);

    logic             late_win;
    logic [LANES-1:0] be_half;

    // Phase windows and byte enables of the half being written.
    always_comb begin
        late_win = (state inside {ST_Q3, ST_Q4, ST_Q5});
        ras_n    = !(state inside {ST_Q2, ST_Q3, ST_Q4, ST_Q5});
        cs_n     = (state == ST_IDLE);
        dq_oe    = (state != ST_IDLE);
        rd_n     = 1'b1;
        be_half  = half ? be_q[LANES-1:0] : be_q[2*LANES-1:LANES];
    end

    // Per-lane strobe mapping; mode_q picks which line carries the byte enable.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic lane_en;
        assign lane_en  = be_half[LANES-1-i];
        assign cas_n[i] = !(late_win && (mode_q ? lane_en : (i == 0)));
        assign we_n[i]  = !(late_win && (mode_q ? (i == 0) : lane_en));
    end

    assert_cas_needs_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (~cas_n != '0) |-> !ras_n);

    assert_ras_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |=> !ras_n);

    assert_we_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (~we_n != '0) |-> dq_oe);

endmodule

// File: rtl/dram_wr_seq.sv
// Top: DRAM word write sequencer. Splits a 32-bit write into two 16-bit
// half-word DRAM write cycles of five states each, lower half-word address
// first, with selectable single-CAS/dual-WE or dual-CAS/single-WE strobes.
// Assumes: the data pins are D31..D16 of the external bus; dq_oe low means
// the pins are released.
module dram_wr_seq
    import dram_wr_pkg::*;
#(
    parameter int WADDR_W = 22,
    parameter int COL_W   = 8,
    parameter int HALF_W  = 16,
    localparam int WORD_W = 2 * HALF_W,
    localparam int LANES  = HALF_W / 8,
    localparam int BE_W   = 2 * LANES,
    localparam int ROW_W  = WADDR_W + 1 - COL_W,
    localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_sel,
    input  logic               req_valid,
    input  logic [WADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0]  req_data,
    input  logic [BE_W-1:0]    req_be,
    output logic               busy,
    output logic               done,
    output logic [MUX_W-1:0]   dram_addr,
    output logic [HALF_W-1:0]  dq_o,
    output logic               dq_oe,
    output logic               ras_n,
    output logic [LANES-1:0]   cas_n,
    output logic [LANES-1:0]   we_n,
    output logic               cs_n,
    output logic               rd_n
);

    seq_state_t         state;
    logic               half;
    logic [WADDR_W-1:0] addr_q;
    logic [WORD_W-1:0]  data_q;
    logic [BE_W-1:0]    be_q;
    logic               mode_q;

    dram_wr_fsm #(.WADDR_W(WADDR_W), .WORD_W(WORD_W), .BE_W(BE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_be(req_be), .mode_sel(mode_sel),
        .state(state), .half(half), .addr_q(addr_q), .data_q(data_q),
        .be_q(be_q), .mode_q(mode_q), .busy(busy), .done(done)
    );

    dram_wr_addr #(.WADDR_W(WADDR_W), .COL_W(COL_W)) u_addr (
        .addr_q(addr_q), .half(half), .state(state), .mux_addr(dram_addr)
    );

    dram_wr_strobe #(.LANES(LANES)) u_strobe (
        .clk(clk), .rst_n(rst_n), .state(state), .half(half), .be_q(be_q),
        .mode_q(mode_q), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cs_n(cs_n), .rd_n(rd_n), .dq_oe(dq_oe)
    );

    // Data of the current half; first half takes the upper bits of the word.
    always_comb begin
        if (!busy)     dq_o = '0;
        else if (half) dq_o = data_q[HALF_W-1:0];
        else           dq_o = data_q[WORD_W-1:HALF_W];
    end

    assert_select_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cs_n);

    assert_drive_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> busy);

endmodule

// File: tb/test_dram_wr_seq.sv
`timescale 1ns/1ps
// Directed bench for dram_wr_seq: one task per scenario, each checking
// every cycle of its word write against values derived from the requirements.
module test_dram_wr_seq;
    localparam int WADDR_W = 22;
    localparam int COL_W   = 8;
    localparam int MUX_W   = 15;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               mode_sel = 1'b0;
    logic               req_valid = 1'b0;
    logic [WADDR_W-1:0] req_addr = '0;
    logic [31:0]        req_data = '0;
    logic [3:0]         req_be = '0;
    logic               busy, done, dq_oe, ras_n, cs_n, rd_n;
    logic [MUX_W-1:0]   dram_addr;
    logic [15:0]        dq_o;
    logic [1:0]         cas_n, we_n;

    int n_checks = 0;
    int n_fails  = 0;

    dram_wr_seq #(.WADDR_W(WADDR_W), .COL_W(COL_W), .HALF_W(16)) i_dram_wr_seq (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .req_valid(req_valid),
        .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
        .busy(busy), .done(done), .dram_addr(dram_addr), .dq_o(dq_o),
        .dq_oe(dq_oe), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cs_n(cs_n), .rd_n(rd_n)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One word write; inject=1 disturbs inputs while busy (R9, R10).
    task automatic do_write(input logic [WADDR_W-1:0] a, input logic [31:0] d,
                            input logic [3:0] be, input bit m, input bit inject);
        @(negedge clk);
        mode_sel = m; req_addr = a; req_data = d; req_be = be; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 1; c <= 10; c++) begin
            int h = (c - 1) / 5;
            int q = (c - 1) % 5 + 1;
            logic [22:0] ha  = {a, h[0]};
            logic [14:0] row = 15'(ha >> COL_W);
            logic [14:0] col = {7'd0, ha[7:0]};
            logic [1:0]  b2  = h ? be[1:0] : be[3:2];
            logic        act = (q >= 3);
            logic [1:0]  e_cas, e_we;
            string       st  = m ? "R8" : "R7";
            if (inject) st = {st, " R9"};
            if (m) begin
                e_cas = {~(act & b2[0]), ~(act & b2[1])};
                e_we  = {1'b1, ~act};
            end else begin
                e_cas = {1'b1, ~act};
                e_we  = {~(act & b2[0]), ~(act & b2[1])};
            end
            chk("R2 busy", 32'(busy), 32'd1);
            chk("R5 addr", 32'(dram_addr), 32'(q <= 2 ? row : col));
            chk("R5 data", 32'(dq_o), 32'(h ? d[15:0] : d[31:16]));
            chk("R3 oe", 32'(dq_oe), 32'd1);
            chk("R4 ras", 32'(ras_n), 32'(q < 2));
            chk({st, " R4 cas"}, 32'(cas_n), 32'(e_cas));
            chk({st, " R4 we"}, 32'(we_n), 32'(e_we));
            chk("R6 cs", 32'(cs_n), 32'd0);
            chk("R6 rd", 32'(rd_n), 32'd1);
            chk("R11 done low", 32'(done), 32'd0);
            if (inject && c == 2) begin
                req_valid = 1'b1; req_addr = ~a; req_data = ~d; req_be = ~be; mode_sel = ~m;
            end
            if (inject && c == 9) req_valid = 1'b0;
            @(negedge clk);
        end
        chk("R11 done", 32'(done), 32'd1);
        chk("R11 busy", 32'(busy), 32'd0);
        chk("R3 oe off", 32'(dq_oe), 32'd0);
        @(negedge clk);
        chk("R11 done one cycle", 32'(done), 32'd0);
        chk("R10 idle after", 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 ras", 32'(ras_n), 32'd1);
        chk("R1 cas", 32'(cas_n), 32'd3);
        chk("R1 we", 32'(we_n), 32'd3);
        chk("R1 cs", 32'(cs_n), 32'd1);
        chk("R1 rd", 32'(rd_n), 32'd1);
        chk("R1 oe", 32'(dq_oe), 32'd0);
    endtask

    task automatic t_word_single_cas();  do_write(22'h12345, 32'hCAFE_BABE, 4'hF, 1'b0, 1'b0); endtask
    task automatic t_word_dual_cas();    do_write(22'h2A5A5, 32'h1234_5678, 4'hF, 1'b1, 1'b0); endtask
    task automatic t_bytes_single_cas(); do_write(22'h0007F, 32'hA1B2_C3D4, 4'b1001, 1'b0, 1'b0); endtask
    task automatic t_bytes_dual_cas();   do_write(22'h3FF80, 32'h5566_7788, 4'b0110, 1'b1, 1'b0); endtask
    task automatic t_one_byte();         do_write(22'h00100, 32'h0000_00EE, 4'b0001, 1'b1, 1'b0); endtask
    task automatic t_busy_ignore();      do_write(22'h15555, 32'h0F0F_F0F0, 4'b1010, 1'b0, 1'b1); endtask

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_word_single_cas();
        t_word_dual_cas();
        t_bytes_single_cas();
        t_bytes_dual_cas();
        t_one_byte();
        t_busy_ignore();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule